// File: doc/BRIEF.md
# Bidirectional Storing Bus Transceiver Datapath

This block moves an 8-bit word between two sides, A and B. Each direction has its own storage element. A shared latch-enable level and a capture clock for that direction decide how the element behaves. With latch enable high it is transparent. With latch enable low it holds its value, and it loads a new word only when its capture clock rises. Data always passes through true, never inverted.

An active-low output enable and a direction select decide which side drives. With the enable high, neither side drives. With the enable low, the select picks A-to-B or B-to-A. Each side's output is a data vector plus a drive flag, so tri-state buffers can be placed at the chip edge.

The model is fully synchronous. A free-running system clock samples every control. A capture clock counts as rising when it is sampled low in one system cycle and high in the next. Every output is registered and lags its inputs by one system cycle.

Top module: `bidir_hold_xcvr`

## Requirements
- R1: In the cycle after output enable `oeN` is sampled high, both `aDrive` and `bDrive` are 0 (isolation), regardless of the other inputs.
- R2: In the cycle after `oeN` is sampled low, `dirAtoB`=1 gives `bDrive`=1 with `aDrive`=0, and `dirAtoB`=0 gives `aDrive`=1 with `bDrive`=0.
- R3: While `latchEn` is sampled high, `bOut` equals the `aIn` value sampled at the previous system clock edge (transparent with one cycle of lag).
- R4: While `latchEn` is sampled low and `clkAtoB` shows no rising edge, `bOut` holds its value. This includes the case where the capture clock was already high when `latchEn` fell.
- R5: With `latchEn` low, a rising edge of `clkAtoB` loads the current `aIn`, and that value appears on `bOut` after the same system clock edge. A rising edge means sampled 0 in one cycle and sampled 1 in the next, and it counts across reset.
- R6: The B-to-A path follows the same transparent, hold and capture rules, from `bIn` to `aOut`. It uses its own clock `clkBtoA` and shares the same `latchEn`.
- R7: Every bit passes through true: in transparent mode `bOut` and `aOut` equal their sources exactly, and no bit is inverted.
- R8: A synchronous active-high `rst` clears both stored words to 0 and forces both drive flags to 0 after the next system clock edge.
- R9: The stored words keep updating while the outputs are not driven. A word captured during isolation appears, driven, once the output is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock; samples every control |
| rst | input | 1 | Synchronous reset, active high |
| oeN | input | 1 | Shared output enable, active low |
| dirAtoB | input | 1 | 1 = drive A data to B, 0 = drive B data to A |
| latchEn | input | 1 | Shared latch enable; high = transparent |
| clkAtoB | input | 1 | Capture clock for the A-to-B store |
| clkBtoA | input | 1 | Capture clock for the B-to-A store |
| aIn | input | W | Data arriving on the A side |
| bIn | input | W | Data arriving on the B side |
| aOut | output | W | Stored B-to-A word presented to side A |
| aDrive | output | 1 | Side A drive enable |
| bOut | output | W | Stored A-to-B word presented to side B |
| bDrive | output | 1 | Side B drive enable |

## Verification
Two functions can fall in the same system cycle: a capture-clock rising edge and a change in output enable or direction. In that cycle the store loads a new word while the drive flag switches on or off. The stimulus table provokes this in two ways. One row raises `clkAtoB` while the outputs are isolated, and the next row enables B. Another row flips the direction while both capture clocks rise together. Each case is judged against a reference model in the bench, which tracks the stored words and drive flags separately. A second collision is latch enable falling in the same cycle as a held-high clock, which must not count as a capture.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned DIR_AB = 0;
  localparam int unsigned DIR_BA = 1;
  localparam int unsigned NUM_DIR = 2;

  typedef struct packed {
    logic [NUM_DIR-1:0] load;   // load request per direction store
    logic [NUM_DIR-1:0] drive;  // drive flag per destination side
  } xcvrStrobe_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic        sysClk,
  input  logic        rst,
  input  logic        oeN,
  input  logic        dirAtoB,
  input  logic        latchEn,
  input  logic        clkAtoB,
  input  logic        clkBtoA,
  output xcvrStrobe_t strobe
);
  logic [NUM_DIR-1:0] dirClk;
  logic [NUM_DIR-1:0] prevClk;
  logic [NUM_DIR-1:0] driveQ;
  logic [NUM_DIR-1:0] driveNext;

  assign dirClk[DIR_AB] = clkAtoB;
  assign dirClk[DIR_BA] = clkBtoA;

  // The previous sample tracks the clocks during reset as well, so an edge
  // spanning the end of reset is still recognised.
  always_ff @(posedge sysClk) begin
    prevClk <= dirClk;
  end

  always_comb begin
    driveNext[DIR_AB] = ~oeN & dirAtoB;
    driveNext[DIR_BA] = ~oeN & ~dirAtoB;
  end

  always_ff @(posedge sysClk) begin
    if (rst) driveQ <= '0;
    else     driveQ <= driveNext;
  end

  always_comb begin
    for (int d = 0; d < NUM_DIR; d++) begin
      strobe.load[d] = latchEn | (dirClk[d] & ~prevClk[d]);
    end
    strobe.drive = driveQ;
  end
endmodule

// File: rtl/xcvr_lanes.sv
module xcvr_lanes
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic          sysClk,
  input  logic          rst,
  input  xcvrStrobe_t   strobe,
  input  logic [W-1:0]  aIn,
  input  logic [W-1:0]  bIn,
  output logic [W-1:0]  aOut,
  output logic          aDrive,
  output logic [W-1:0]  bOut,
  output logic          bDrive
);
  logic [W-1:0] srcWord [NUM_DIR];
  logic [W-1:0] heldWord[NUM_DIR];

  assign srcWord[DIR_AB] = aIn;
  assign srcWord[DIR_BA] = bIn;

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_store
    always_ff @(posedge sysClk) begin
      if (rst)                heldWord[g] <= '0;
      else if (strobe.load[g]) heldWord[g] <= srcWord[g];
    end
  end

  assign bOut   = heldWord[DIR_AB];
  assign aOut   = heldWord[DIR_BA];
  assign bDrive = strobe.drive[DIR_AB];
  assign aDrive = strobe.drive[DIR_BA];
endmodule

// File: rtl/bidir_hold_xcvr.sv
module bidir_hold_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic          sysClk,
  input  logic          rst,
  input  logic          oeN,
  input  logic          dirAtoB,
  input  logic          latchEn,
  input  logic          clkAtoB,
  input  logic          clkBtoA,
  input  logic [W-1:0]  aIn,
  input  logic [W-1:0]  bIn,
  output logic [W-1:0]  aOut,
  output logic          aDrive,
  output logic [W-1:0]  bOut,
  output logic          bDrive
);
  xcvrStrobe_t strobe;

  xcvr_ctrl u_ctrl (
    .sysClk (sysClk),
    .rst    (rst),
    .oeN    (oeN),
    .dirAtoB(dirAtoB),
    .latchEn(latchEn),
    .clkAtoB(clkAtoB),
    .clkBtoA(clkBtoA),
    .strobe (strobe)
  );

  xcvr_lanes #(.W(W)) u_lanes (
    .sysClk(sysClk),
    .rst   (rst),
    .strobe(strobe),
    .aIn   (aIn),
    .bIn   (bIn),
    .aOut  (aOut),
    .aDrive(aDrive),
    .bOut  (bOut),
    .bDrive(bDrive)
  );
endmodule

// File: rtl/bidir_hold_xcvr_chk.sv
module bidir_hold_xcvr_chk #(
  parameter int unsigned W = 8
) (
  input logic          sysClk,
  input logic          rst,
  input logic          oeN,
  input logic          dirAtoB,
  input logic          latchEn,
  input logic          clkAtoB,
  input logic          clkBtoA,
  input logic [W-1:0]  aIn,
  input logic [W-1:0]  bIn,
  input logic [W-1:0]  aOut,
  input logic          aDrive,
  input logic [W-1:0]  bOut,
  input logic          bDrive
);
  p_isolate_r1: assert property (@(posedge sysClk) disable iff (rst)
    oeN |=> (!aDrive && !bDrive));

  p_dir_ab_r2: assert property (@(posedge sysClk) disable iff (rst)
    (!oeN && dirAtoB) |=> (bDrive && !aDrive));

  p_dir_ba_r2: assert property (@(posedge sysClk) disable iff (rst)
    (!oeN && !dirAtoB) |=> (aDrive && !bDrive));

  p_transparent_r3: assert property (@(posedge sysClk) disable iff (rst)
    latchEn |=> (bOut == $past(aIn)));

  p_hold_r4: assert property (@(posedge sysClk) disable iff (rst)
    (!latchEn && !(clkAtoB && !$past(clkAtoB))) |=> $stable(bOut));

  p_capture_r5: assert property (@(posedge sysClk) disable iff (rst)
    (!latchEn && clkAtoB && !$past(clkAtoB)) |=> (bOut == $past(aIn)));

  p_capture_ba_r6: assert property (@(posedge sysClk) disable iff (rst)
    (!latchEn && clkBtoA && !$past(clkBtoA)) |=> (aOut == $past(bIn)));

  p_hold_ba_r6: assert property (@(posedge sysClk) disable iff (rst)
    (!latchEn && !(clkBtoA && !$past(clkBtoA))) |=> $stable(aOut));

  p_reset_r8: assert property (@(posedge sysClk)
    rst |=> (aOut == '0 && bOut == '0 && !aDrive && !bDrive));
endmodule

bind bidir_hold_xcvr bidir_hold_xcvr_chk #(.W(W)) u_chk (
  .sysClk (sysClk),
  .rst    (rst),
  .oeN    (oeN),
  .dirAtoB(dirAtoB),
  .latchEn(latchEn),
  .clkAtoB(clkAtoB),
  .clkBtoA(clkBtoA),
  .aIn    (aIn),
  .bIn    (bIn),
  .aOut   (aOut),
  .aDrive (aDrive),
  .bOut   (bOut),
  .bDrive (bDrive)
);

// File: tb/tb_bidir_hold_xcvr.sv
module tb_bidir_hold_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;

  // Row layout: rst, oeN, dirAtoB, latchEn, clkAtoB, clkBtoA, aIn[7:0], bIn[7:0]
  localparam logic [21:0] VEC [NV] = '{
    {1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,8'hAA,8'h55},
    {1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,8'h3C,8'h11},
    {1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,8'h5A,8'h22},
    {1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'h77,8'h33},
    {1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'h88,8'h34},
    {1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h99,8'h35},
    {1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,8'h66,8'h44},
    {1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'hF0,8'h0F},
    {1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,8'hE1,8'h1E},
    {1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'h2D,8'h1E},
    {1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,8'hC3,8'hD2},
    {1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,8'h12,8'h21},
    {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h13,8'h31},
    {1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'hAB,8'hCD},
    {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'hBC,8'hDE},
    {1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,8'h4F,8'hF4},
    {1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,8'h70,8'h07},
    {1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h81,8'h5E},
    {1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h90,8'h09}
  };

  logic       sysClk = 1'b0;
  logic       rst = 1'b1;
  logic       oeN = 1'b1;
  logic       dirAtoB = 1'b0;
  logic       latchEn = 1'b0;
  logic       clkAtoB = 1'b0;
  logic       clkBtoA = 1'b0;
  logic [7:0] aIn = '0;
  logic [7:0] bIn = '0;
  logic [7:0] aOut, bOut;
  logic       aDrive, bDrive;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference model state
  logic [7:0] mAb = '0, mBa = '0;
  logic       mDa = 1'b0, mDb = 1'b0, mPab = 1'b0, mPba = 1'b0;

  always #(CLK_PERIOD/2) sysClk = ~sysClk;

  bidir_hold_xcvr #(.W(8)) dut (
    .sysClk(sysClk), .rst(rst), .oeN(oeN), .dirAtoB(dirAtoB),
    .latchEn(latchEn), .clkAtoB(clkAtoB), .clkBtoA(clkBtoA),
    .aIn(aIn), .bIn(bIn), .aOut(aOut), .aDrive(aDrive),
    .bOut(bOut), .bDrive(bDrive)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic apply(input logic [21:0] v);
    @(negedge sysClk);
    {rst, oeN, dirAtoB, latchEn, clkAtoB, clkBtoA, aIn, bIn} = v;
  endtask

  // Advance one edge, update the model from the sampled inputs, and compare.
  task automatic stepCheck();
    string tagB, tagA, tagD;
    logic edgeAb, edgeBa;
    @(posedge sysClk);
    edgeAb = clkAtoB && !mPab;
    edgeBa = clkBtoA && !mPba;
    if (rst) begin
      mAb = '0; mBa = '0; mDa = 0; mDb = 0;
      tagB = "R8 bOut"; tagA = "R8 aOut"; tagD = "R8 drive";
    end else begin
      if (latchEn || edgeAb) mAb = aIn;
      if (latchEn || edgeBa) mBa = bIn;
      mDb = !oeN && dirAtoB;
      mDa = !oeN && !dirAtoB;
      tagB = latchEn ? "R3 bOut" : (edgeAb ? "R5 bOut" : "R4 bOut");
      tagA = latchEn ? "R6 aOut transparent" : (edgeBa ? "R6 aOut capture" : "R6 aOut hold");
      tagD = oeN ? "R1 drive" : "R2 drive";
    end
    mPab = clkAtoB;
    mPba = clkBtoA;
    #1;
    chk(tagB, bOut, mAb);
    chk(tagA, aOut, mBa);
    chk({tagD, " bDrive"}, {7'd0, bDrive}, {7'd0, mDb});
    chk({tagD, " aDrive"}, {7'd0, aDrive}, {7'd0, mDa});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // Table walk against the reference model (covers R1..R6, R8, R9)
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      stepCheck();
    end

    // R9: captured while isolated, then shown once enabled
    apply({1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00});
    stepCheck();
    apply({1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,8'h6B,8'h00});
    stepCheck();
    apply({1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'h00,8'h00});
    @(posedge sysClk); #1;
    chk("R9 isolated capture shown", bOut, 8'h6B);
    chk("R9 bDrive after enable", {7'd0, bDrive}, 8'd1);
    mPab = 1'b1; mPba = 1'b0; mAb = 8'h6B; mDb = 1; mDa = 0;

    // R7: true data, single-bit and complementary patterns both ways
    apply({1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,8'h01,8'hFE});
    @(posedge sysClk); #1;
    chk("R7 bOut true 01", bOut, 8'h01);
    chk("R7 aOut true FE", aOut, 8'hFE);
    apply({1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,8'h80,8'h7F});
    @(posedge sysClk); #1;
    chk("R7 bOut true 80", bOut, 8'h80);
    chk("R7 aOut true 7F", aOut, 8'h7F);

    // R8: directed reset clears everything
    apply({1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,8'hFF,8'hFF});
    @(posedge sysClk); #1;
    chk("R8 bOut cleared", bOut, 8'h00);
    chk("R8 aOut cleared", aOut, 8'h00);
    chk("R8 drives off", {6'd0, aDrive, bDrive}, 8'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule